// File: doc/BRIEF.md
# Block Lock Command Sequencer

This block accepts bus writes that form a two-step lock request for a memory array divided into equal blocks, and holds one lock bit per block. The lock bits leave the block as a vector for the program and erase paths, which must refuse to alter any block whose bit is set. The first write arms the sequencer and the second names the block and confirms. A valid request starts a modelled nonvolatile write that keeps the ready bit low for a parameterised number of cycles. When that time ends, the block's bit is set, unless the write-protect supply is then too low.

A status byte reports readiness and three sticky error flags. A flag selects status-read mode: once a lock sequence completes its second write, reads must return the status byte until the next command arrives. A request is refused when the internal engine is busy or the device is suspended, and the refusal is reported as a malformed sequence. Errors stay set until a clear-status command.

Top module: `blklock_seq`

## Requirements
- R1: After reset all lock bits are 0, the status byte reads 80h and the status-mode flag is 0.
- R2: A write of 60h followed by a write of 01h with wr_blk = b drives status bit 7 to 0 for exactly LOCK_CYCLES cycles after the confirm edge; at the end of that interval lock bit b becomes 1 and bit 7 returns to 1.
- R3: A lock bit, once set, stays 1 until reset, and locking an already locked block leaves it set.
- R4: If the write after 60h carries any byte other than 01h, status bits 5 and 4 become 1 one cycle later, bit 7 stays 1 and no lock bit changes.
- R5: A 60h write or a confirm write made while engine_busy or suspended is high is refused: status bits 5 and 4 become 1, and no lock bit changes.
- R6: If prot_ok is low on the final cycle of the lock interval, status bits 4 and 3 become 1 and no lock bit changes; lock bits never change on a cycle following one with prot_ok low.
- R7: Status bits 5, 4 and 3 are sticky; a 50h write made while idle clears all three on the next cycle and leaves bit 7 unchanged.
- R8: stat_mode becomes 1 after the second write of a lock sequence, and after a refused 60h write; it becomes 0 after any other write accepted while idle (a fresh 60h, 50h, or any other byte).
- R9: Writes that arrive while the lock interval is running, including on its final cycle, are ignored.
- R10: Status bits 6, 2, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_blk | input | IDX_W (3) | Block-select field of the write address |
| wr_data | input | 8 | Command byte |
| engine_busy | input | 1 | Internal program/erase engine is running |
| suspended | input | 1 | Device is in a suspended state |
| prot_ok | input | 1 | Write-protect supply is above the lockout level |
| lock_bits | output | NUM_BLOCKS (8) | One lock bit per block |
| status | output | 8 | Status byte: 7 ready, 5 sequence error, 4 lock error, 3 supply error |
| stat_mode | output | 1 | Reads return the status byte when 1 |

## Verification
Two events can fall on the same edge: the end of the lock interval, and a bus write or a change of the protect supply. The bench drops prot_ok only for the last busy cycle, so an early or late sampling point is seen as a wrong lock bit or a wrong error flag. In another pass it issues a 60h write on that same final cycle and then checks that stat_mode stays 1, which shows the write was discarded rather than taken as a new command.

// File: rtl/blklock_pkg.sv
package blklock_pkg;

    localparam logic [7:0] CMD_ARM     = 8'h60;
    localparam logic [7:0] CMD_CONFIRM = 8'h01;
    localparam logic [7:0] CMD_CLRSTAT = 8'h50;

    typedef enum logic {
        DEC_IDLE,
        DEC_ARMED
    } dec_state_e;

    typedef struct packed {
        logic       ready;
        logic       rsv6;
        logic       seq_err;
        logic       lock_err;
        logic       prot_err;
        logic [2:0] rsv;
    } stat_t;

    typedef struct packed {
        logic start;
        logic seq_err;
        logic clr;
        logic mode_set;
        logic mode_clr;
    } dec_evt_t;

    function automatic stat_t stat_pack(input logic rdy, input logic e5,
                                        input logic e4, input logic e3);
        stat_t s;
        s          = '0;
        s.ready    = rdy;
        s.seq_err  = e5;
        s.lock_err = e4;
        s.prot_err = e3;
        return s;
    endfunction

endpackage

// File: rtl/blklock_decoder.sv
module blklock_decoder
    import blklock_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_blk,
    input  logic [7:0]       wr_data,
    input  logic             engine_busy,
    input  logic             suspended,
    input  logic             lock_busy,
    output dec_evt_t         evt,
    output logic [IDX_W-1:0] target
);

    dec_state_e       state_q, state_d;
    logic [IDX_W-1:0] tgt_q, tgt_d;
    logic             blocked;

    assign blocked = engine_busy | suspended;

    always_comb begin
        evt     = '0;
        state_d = state_q;
        tgt_d   = tgt_q;
        if (wr_en && !lock_busy) begin
            case (state_q)
                DEC_IDLE: begin
                    if (wr_data == CMD_ARM) begin
                        if (blocked) begin
                            evt.seq_err  = 1'b1;
                            evt.mode_set = 1'b1;
                        end else begin
                            state_d      = DEC_ARMED;
                            evt.mode_clr = 1'b1;
                        end
                    end else if (wr_data == CMD_CLRSTAT) begin
                        evt.clr      = 1'b1;
                        evt.mode_clr = 1'b1;
                    end else begin
                        evt.mode_clr = 1'b1;
                    end
                end
                DEC_ARMED: begin
                    state_d      = DEC_IDLE;
                    evt.mode_set = 1'b1;
                    if (wr_data == CMD_CONFIRM && !blocked) begin
                        evt.start = 1'b1;
                        tgt_d     = wr_blk;
                    end else begin
                        evt.seq_err = 1'b1;
                    end
                end
                default: state_d = DEC_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DEC_IDLE;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
        end
    end

    assign target = tgt_q;

    // R9: decoder state and target frozen while the lock interval runs
    p_busy_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        lock_busy |=> ($stable(state_q) && $stable(tgt_q)));

    // R2: an armed sequencer always leaves the armed state on the next write
    p_armed_exit_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == DEC_ARMED && wr_en) |=> (state_q == DEC_IDLE));

endmodule

// File: rtl/blklock_timer.sv
module blklock_timer #(
    parameter int LOCK_CYCLES = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    assign done = busy_q && (cnt_q == '0);
    assign busy = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= CNT_W'(LOCK_CYCLES - 1);
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // R2: a start request opens the busy interval on the next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R2: busy cannot end before the count reaches zero
    p_no_early_end_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt_q != '0) |=> busy);

endmodule

// File: rtl/blklock_array.sv
module blklock_array #(
    parameter int NUM_BLOCKS = 8,
    parameter int IDX_W      = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  commit,
    input  logic [IDX_W-1:0]      target,
    output logic [NUM_BLOCKS-1:0] lock_q
);

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                lock_q[i] <= 1'b0;
            end else if (commit && target == IDX_W'(i)) begin
                lock_q[i] <= 1'b1;
            end
        end

        // R3: a set lock bit never clears outside reset
        p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
            lock_q[i] |=> lock_q[i]);
    end

endmodule

// File: rtl/blklock_status.sv
module blklock_status
    import blklock_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  busy,
    input  logic  seq_err,
    input  logic  prot_fail,
    input  logic  clr,
    input  logic  mode_set,
    input  logic  mode_clr,
    output stat_t stat,
    output logic  mode
);

    logic e5_q, e4_q, e3_q, mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            e5_q   <= 1'b0;
            e4_q   <= 1'b0;
            e3_q   <= 1'b0;
            mode_q <= 1'b0;
        end else begin
            if (clr) begin
                e5_q <= 1'b0;
                e4_q <= 1'b0;
                e3_q <= 1'b0;
            end
            if (seq_err) begin
                e5_q <= 1'b1;
                e4_q <= 1'b1;
            end
            if (prot_fail) begin
                e4_q <= 1'b1;
                e3_q <= 1'b1;
            end
            if (mode_set) begin
                mode_q <= 1'b1;
            end else if (mode_clr) begin
                mode_q <= 1'b0;
            end
        end
    end

    assign stat = stat_pack(!busy, e5_q, e4_q, e3_q);
    assign mode = mode_q;

    // R4: a malformed sequence raises bits 5 and 4
    p_seq_flags_r4: assert property (@(posedge clk) disable iff (rst)
        seq_err |=> (stat.seq_err && stat.lock_err));

    // R6: a supply lockout raises bits 4 and 3
    p_prot_flags_r6: assert property (@(posedge clk) disable iff (rst)
        prot_fail |=> (stat.lock_err && stat.prot_err));

    // R7: error flags hold without a clear
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr && stat.seq_err) |=> stat.seq_err);

    // R10: reserved bits stay low
    p_rsv_zero_r10: assert property (@(posedge clk) disable iff (rst)
        (stat.rsv6 == 1'b0 && stat.rsv == 3'b000));

endmodule

// File: rtl/blklock_seq.sv
module blklock_seq
    import blklock_pkg::*;
#(
    parameter int NUM_BLOCKS  = 8,
    parameter int LOCK_CYCLES = 6,
    localparam int IDX_W      = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_blk,
    input  logic [7:0]            wr_data,
    input  logic                  engine_busy,
    input  logic                  suspended,
    input  logic                  prot_ok,
    output logic [NUM_BLOCKS-1:0] lock_bits,
    output logic [7:0]            status,
    output logic                  stat_mode
);

    dec_evt_t         evt;
    logic [IDX_W-1:0] target;
    logic             busy, done, commit, prot_fail;
    stat_t            stat;

    assign commit    = done &  prot_ok;
    assign prot_fail = done & ~prot_ok;

    blklock_decoder #(.IDX_W(IDX_W)) u_dec (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_blk      (wr_blk),
        .wr_data     (wr_data),
        .engine_busy (engine_busy),
        .suspended   (suspended),
        .lock_busy   (busy),
        .evt         (evt),
        .target      (target)
    );

    blklock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (evt.start),
        .busy  (busy),
        .done  (done)
    );

    blklock_array #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_arr (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .target (target),
        .lock_q (lock_bits)
    );

    blklock_status u_stat (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .seq_err   (evt.seq_err),
        .prot_fail (prot_fail),
        .clr       (evt.clr),
        .mode_set  (evt.mode_set),
        .mode_clr  (evt.mode_clr),
        .stat      (stat),
        .mode      (stat_mode)
    );

    assign status = stat;

    // R6: with the supply in lockout, the lock vector cannot move
    p_prot_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        !prot_ok |=> $stable(lock_bits));

    // R5: a refused request never starts the lock interval
    p_refuse_r5: assert property (@(posedge clk) disable iff (rst)
        (engine_busy || suspended) |=> !$rose(busy));

endmodule

// File: tb/blklock_seq_tb.sv
module blklock_seq_tb;

    localparam int NB  = 8;
    localparam int LC  = 6;
    localparam int IW  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_blk = '0;
    logic [7:0]    wr_data = '0;
    logic          engine_busy = 1'b0;
    logic          suspended = 1'b0;
    logic          prot_ok = 1'b1;
    logic [NB-1:0] lock_bits;
    logic [7:0]    status;
    logic          stat_mode;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    logic [NB-1:0] m_lock = '0;
    logic          m_e5 = 0, m_e4 = 0, m_e3 = 0, m_mode = 0;

    always #10 clk = ~clk;

    blklock_seq #(.NUM_BLOCKS(NB), .LOCK_CYCLES(LC)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_blk(wr_blk), .wr_data(wr_data),
        .engine_busy(engine_busy), .suspended(suspended), .prot_ok(prot_ok),
        .lock_bits(lock_bits), .status(status), .stat_mode(stat_mode)
    );

    function automatic logic [7:0] exp_status(input logic rdy);
        return {rdy, 1'b0, m_e5, m_e4, m_e3, 3'b000};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " lock"}, 32'(lock_bits), 32'(m_lock));
        check({tag, " status (R10)"}, 32'(status), 32'(exp_status(1'b1)));
        check({tag, " mode"}, 32'(stat_mode), 32'(m_mode));
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic bus_wr(input logic [IW-1:0] b, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_blk = b; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // full lock sequence; prot_ok is forced to fin_prot only on the last busy cycle
    task automatic do_lock(input logic [IW-1:0] b, input logic fin_prot, input bit late_wr);
        bus_wr(IW'($urandom), 8'h60);
        m_mode = 0;
        check("R8 mode after arm", 32'(stat_mode), 32'(0));
        bus_wr(b, 8'h01);
        m_mode = 1;
        for (int i = 0; i < LC; i++) begin
            check("R2 ready low during lock", 32'(status[7]), 32'(0));
            if (i == LC - 1) begin
                prot_ok = fin_prot;
                if (late_wr) begin
                    wr_en = 1'b1; wr_blk = '0; wr_data = 8'h60;
                end
            end
            @(negedge clk);
            wr_en = 1'b0;
            prot_ok = 1'b1;
        end
        if (fin_prot) m_lock[b] = 1'b1;
        else begin m_e4 = 1; m_e3 = 1; end
        check_all(fin_prot ? "R2 R3 lock done" : "R6 lockout");
    endtask

    task automatic do_bad_confirm(input logic [IW-1:0] b);
        logic [7:0] d;
        d = 8'($urandom);
        if (d == 8'h01) d = 8'h02;
        bus_wr(b, 8'h60);
        bus_wr(b, d);
        m_e5 = 1; m_e4 = 1; m_mode = 1;
        check_all("R4 bad confirm");
    endtask

    task automatic do_refused(input logic [IW-1:0] b, input bit at_confirm, input bit use_susp);
        if (at_confirm) begin
            bus_wr(b, 8'h60);
        end
        if (use_susp) suspended = 1'b1; else engine_busy = 1'b1;
        bus_wr(b, at_confirm ? 8'h01 : 8'h60);
        suspended = 1'b0; engine_busy = 1'b0;
        m_e5 = 1; m_e4 = 1; m_mode = 1;
        check_all("R5 refused");
    endtask

    task automatic do_clear();
        bus_wr('0, 8'h50);
        m_e5 = 0; m_e4 = 0; m_e3 = 0; m_mode = 0;
        check_all("R7 R8 clear");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        fails++;
        checks++;
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 reset lock", 32'(lock_bits), 32'(0));
        check("R1 reset status", 32'(status), 32'h80);
        check("R1 reset mode", 32'(stat_mode), 32'(0));
        rst = 1'b0;
        @(negedge clk);
        check_all("R1 after release");

        // directed corners
        do_lock(3'd5, 1'b1, 1'b0);                 // R2
        do_lock(3'd5, 1'b1, 1'b0);                 // R3 relock
        do_lock(3'd2, 1'b0, 1'b0);                 // R6 drop on final cycle only
        do_clear();                                // R7
        do_lock(3'd1, 1'b1, 1'b1);                 // R9 write on final busy cycle
        check("R9 late write ignored mode", 32'(stat_mode), 32'(1));
        bus_wr('0, 8'hFF);
        m_mode = 0;
        check_all("R8 other command");
        do_bad_confirm(3'd7);                      // R4
        do_lock(3'd7, 1'b1, 1'b0);
        check("R7 sticky after lock", 32'(status[5:3]), 32'b110);
        do_clear();
        do_refused(3'd0, 1'b0, 1'b0);              // R5 at arm
        do_clear();
        do_refused(3'd0, 1'b1, 1'b1);              // R5 at confirm
        check("R5 block 0 unlocked", 32'(lock_bits[0]), 32'(0));

        // random mix
        for (int n = 0; n < 120; n++) begin
            int unsigned k;
            logic [IW-1:0] b;
            k = $urandom_range(0, 5);
            b = IW'($urandom);
            case (k)
                0: do_lock(b, ($urandom_range(0, 3) != 0), 1'b0);
                1: do_bad_confirm(b);
                2: do_refused(b, 1'($urandom), 1'($urandom));
                3: do_clear();
                4: begin
                    bus_wr(b, 8'hFF);
                    m_mode = 0;
                    check_all("R8 random other");
                end
                default: do_lock(b, 1'b1, 1'($urandom));
            endcase
        end
        finish_run();
    end

endmodule